// File: doc/BRIEF.md
# Streaming Predicate Test Flag Unit

This block derives condition flags from a vector predicate test. A data predicate and a governing predicate arrive together as a stream of 64-bit word pairs, starting at word 0 and moving upward, one pair per cycle while the valid strobe is high. A start pulse clears the running state. A marker on the final word closes the test, and one cycle later a single-cycle done pulse appears with the N, Z, C and V flags and a packed 32-bit flag word.

A bit is active where the governing word has a one. N is the data bit under the lowest active bit of the whole predicate. Z is set when no active data bit is one. C is the inverse of the data bit under the highest active bit of the whole predicate. V is always zero. A predicate of a single word uses the same path, with the last marker raised on its only word.

Top module: `pred_test_flags`

## Requirements
- R1: One word pair is taken on each clock edge where `valid_i` is high. Words are applied in arrival order, and idle cycles between words have no effect.
- R2: After reset, and for any predicate with no governing bit set, the result is N=0, Z=1, C=1.
- R3: A word whose governing word is all zero changes neither the flags nor the internal state, including which word is taken as the first active word.
- R4: N equals the data bit at the lowest set governing bit of the first word that has any governing bit set. Later words do not change N.
- R5: Z is 0 exactly when, in some word, the AND of data and governing words is nonzero. Otherwise Z is 1.
- R6: C is the inverse of the data bit at the highest set governing bit of the last word that has any governing bit set.
- R7: `flag_v_o` is always 0.
- R8: In `flags_o`, bit 31 is N, bit 1 is one when Z is 0, and bit 0 is C. Every other bit is 0.
- R9: `done_o` is high for one cycle, in the cycle after the clock edge that takes a word with `last_i` high. A single-word predicate completes this way.
- R10: A start pulse resets the running state. When no last word is taken in the same cycle, it also returns the outputs to the empty result (`flags_o` = 0x00000001). A word taken in the start cycle is applied on top of the cleared state. Between completions and starts, the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Begin a new predicate test |
| valid_i | input | 1 | A word pair is present this cycle |
| last_i | input | 1 | The present word is the final one |
| data_i | input | 64 | Data predicate word |
| gov_i | input | 64 | Governing predicate word |
| done_o | output | 1 | Result ready, one-cycle pulse |
| flag_n_o | output | 1 | N flag |
| flag_z_o | output | 1 | Z flag |
| flag_c_o | output | 1 | C flag |
| flag_v_o | output | 1 | V flag, constant zero |
| flags_o | output | 32 | Packed flag word |

## Verification
Clearing the state and taking the first word can happen in the same cycle, when the start pulse is raised together with a valid word. If that word is also tagged last, completion falls in the same cycle as well. The bench provokes this with start merged into word 0, for both single-word and multi-word predicates. It judges the outcome against a reference model that applies the word to freshly cleared flags. Two further cases check that the state left by the previous test cannot leak into the new one: a start given alone, and a predicate whose leading words have zero governing words.

// File: rtl/ptest_pkg.sv
package ptest_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned FLAG_W = 32;
  localparam int unsigned N_POS  = FLAG_W - 1;

  // running state of one test; zc is the "some active data bit is one" indicator
  typedef struct packed {
    logic n;
    logic zc;
    logic c;
    logic seen;
  } acc_t;

  localparam acc_t ACC_INIT = '{n: 1'b0, zc: 1'b0, c: 1'b1, seen: 1'b0};
endpackage

// File: rtl/ptest_rst_sync.sv
module ptest_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ptest_word_scan.sv
// Combinational scan of one word pair: finds the lowest and highest governing bits.
module ptest_word_scan #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] gov_i,
  output logic         active_o,
  output logic         lead_bit_o,
  output logic         trail_bit_o,
  output logic         hit_o
);
  logic [W-1:0] lo_oh;
  logic [W-1:0] gov_rev;
  logic [W-1:0] data_rev;
  logic [W-1:0] hi_oh_rev;

  // bit-reverse so the highest governing bit becomes the lowest
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign gov_rev[i]  = gov_i[W-1-i];
    assign data_rev[i] = data_i[W-1-i];
  end

  assign lo_oh     = gov_i & (~gov_i + 1'b1);
  assign hi_oh_rev = gov_rev & (~gov_rev + 1'b1);

  assign active_o    = |gov_i;
  assign lead_bit_o  = |(data_i & lo_oh);
  assign trail_bit_o = |(data_rev & hi_oh_rev);
  assign hit_o       = |(data_i & gov_i);
endmodule

// File: rtl/ptest_flag_acc.sv
module ptest_flag_acc
  import ptest_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  input  logic last_i,
  input  logic active_i,
  input  logic lead_bit_i,
  input  logic trail_bit_i,
  input  logic hit_i,
  output logic res_n_o,
  output logic res_zc_o,
  output logic res_c_o,
  output logic done_o
);
  acc_t acc_q, acc_d, base;
  acc_t res_q, res_d;
  logic acc_en, res_en, done_d, take_last;

  assign take_last = valid_i & last_i;

  // next state of the running accumulator
  always_comb begin
    base  = start_i ? ACC_INIT : acc_q;
    acc_d = base;
    if (valid_i && active_i) begin
      if (!base.seen) begin
        acc_d.n    = lead_bit_i;
        acc_d.seen = 1'b1;
      end
      acc_d.zc = base.zc | hit_i;
      acc_d.c  = ~trail_bit_i;
    end
    acc_en = start_i | valid_i;
  end

  // next state of the held result
  always_comb begin
    res_en = start_i | take_last;
    res_d  = take_last ? acc_d : ACC_INIT;
    done_d = take_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= ACC_INIT;
      res_q  <= ACC_INIT;
      done_o <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (res_en) res_q <= res_d;
      done_o <= done_d;
    end
  end

  assign res_n_o  = res_q.n;
  assign res_zc_o = res_q.zc;
  assign res_c_o  = res_q.c;
endmodule

// File: rtl/ptest_flag_pack.sv
module ptest_flag_pack
  import ptest_pkg::*;
(
  input  logic              n_i,
  input  logic              zc_i,
  input  logic              c_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o,
  output logic              v_o
);
  always_comb begin
    flags_o        = '0;
    flags_o[N_POS] = n_i;
    flags_o[1]     = zc_i;
    flags_o[0]     = c_i;
  end

  assign n_o = n_i;
  assign z_o = ~zc_i;
  assign c_o = c_i;
  assign v_o = 1'b0;
endmodule

// File: rtl/pred_test_flags.sv
module pred_test_flags
  import ptest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] gov_i,
  output logic              done_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic rst_n_sync;
  logic active, lead_bit, trail_bit, hit;
  logic res_n, res_zc, res_c;

  ptest_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  ptest_word_scan #(.W(WORD_W)) u_scan (
    .data_i(data_i), .gov_i(gov_i), .active_o(active),
    .lead_bit_o(lead_bit), .trail_bit_o(trail_bit), .hit_o(hit)
  );

  ptest_flag_acc u_acc (
    .clk(clk), .rst_n(rst_n_sync), .start_i(start_i), .valid_i(valid_i),
    .last_i(last_i), .active_i(active), .lead_bit_i(lead_bit),
    .trail_bit_i(trail_bit), .hit_i(hit), .res_n_o(res_n),
    .res_zc_o(res_zc), .res_c_o(res_c), .done_o(done_o)
  );

  ptest_flag_pack u_pack (
    .n_i(res_n), .zc_i(res_zc), .c_i(res_c), .flags_o(flags_o),
    .n_o(flag_n_o), .z_o(flag_z_o), .c_o(flag_c_o), .v_o(flag_v_o)
  );
endmodule

// File: rtl/ptest_checker.sv
module ptest_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        valid_i,
  input logic        last_i,
  input logic        done_o,
  input logic        flag_n_o,
  input logic        flag_z_o,
  input logic        flag_c_o,
  input logic        flag_v_o,
  input logic [31:0] flags_o
);
  assert_v_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_v_o == 1'b0);

  assert_pack_layout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[31] == flag_n_o && flags_o[1] == !flag_z_o &&
    flags_o[0] == flag_c_o && flags_o[30:2] == '0);

  assert_done_follows_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && last_i) |=> done_o);

  assert_done_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(valid_i && last_i));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !(valid_i && last_i)) |=> $stable(flags_o));

  assert_start_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !valid_i) |=> (flags_o == 32'h0000_0001));
endmodule

bind pred_test_flags ptest_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
  .last_i(last_i), .done_o(done_o), .flag_n_o(flag_n_o),
  .flag_z_o(flag_z_o), .flag_c_o(flag_c_o), .flag_v_o(flag_v_o),
  .flags_o(flags_o)
);

// File: tb/tb_pred_test_flags.sv
`timescale 1ns/1ps
module tb_pred_test_flags;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, valid_i, last_i;
  logic [63:0] data_i, gov_i;
  logic        done_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;
  logic [31:0] flags_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_n, m_zc, m_c, m_seen;
  bit [31:0] ex_flags;
  bit ex_done;

  logic [63:0] dq[4];
  logic [63:0] gq[4];

  always #2 clk = ~clk;

  pred_test_flags dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .last_i(last_i), .data_i(data_i), .gov_i(gov_i), .done_o(done_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .flag_v_o(flag_v_o), .flags_o(flags_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit [31:0] pack_model();
    return {m_n, 29'b0, m_zc, m_c};
  endfunction

  task automatic model_clear();
    m_n = 0; m_zc = 0; m_c = 1; m_seen = 0;
  endtask

  // bit-serial walk over one word
  task automatic model_word(logic [63:0] d, logic [63:0] g);
    bit any = 0;
    bit top_d = 0;
    for (int b = 0; b < 64; b++) begin
      if (g[b]) begin
        if (!m_seen) begin m_n = d[b]; m_seen = 1; end
        if (d[b]) m_zc = 1;
        top_d = d[b];
        any = 1;
      end
    end
    if (any) m_c = !top_d;
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "flags_o", flags_o, ex_flags);
    chk(tag, "done_o", {31'b0, done_o}, {31'b0, ex_done});
    chk(tag, "flag_n_o", {31'b0, flag_n_o}, {31'b0, ex_flags[31]});
    chk(tag, "flag_z_o", {31'b0, flag_z_o}, {31'b0, !ex_flags[1]});
    chk(tag, "flag_c_o", {31'b0, flag_c_o}, {31'b0, ex_flags[0]});
    chk("R7", "flag_v_o", {31'b0, flag_v_o}, 32'b0);
  endtask

  task automatic idle(string tag);
    start_i = 0; valid_i = 0; last_i = 0;
    ex_done = 0;
    tick(tag);
  endtask

  // merge: raise start together with word 0; gap: idle cycle before word 1
  task automatic run(string tag, int nw, bit merge, bit gap);
    if (!merge) begin
      start_i = 1; valid_i = 0; last_i = 0;
      model_clear();
      ex_flags = 32'h1; ex_done = 0;
      tick("R10");
    end
    for (int i = 0; i < nw; i++) begin
      if (gap && i == 1) idle(tag);
      start_i = merge && i == 0;
      valid_i = 1;
      last_i  = (i == nw - 1);
      data_i  = dq[i];
      gov_i   = gq[i];
      if (start_i) begin
        model_clear();
        ex_flags = 32'h1;
      end
      model_word(dq[i], gq[i]);
      if (last_i) ex_flags = pack_model();
      ex_done = last_i;
      tick(tag);
    end
    idle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; start_i = 0; valid_i = 0; last_i = 0;
    data_i = '0; gov_i = '0;
    model_clear();
    ex_flags = 32'h1; ex_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 reset state
    tick("R2");

    // R2 no governing bits at all
    dq[0] = '1; gq[0] = '0; dq[1] = '1; gq[1] = '0;
    run("R2", 2, 0, 0);

    // R9 single word, single active bit, data one -> N=1 Z=0 C=0
    dq[0] = 64'h0000_0000_0001_0000; gq[0] = 64'h0000_0000_0001_0000;
    run("R9", 1, 0, 0);

    // R3 zero governing words before and between active ones
    dq[0] = '1; gq[0] = '0;
    dq[1] = 64'h1; gq[1] = 64'h3;
    dq[2] = '0;  gq[2] = '0;
    dq[3] = '1;  gq[3] = '0;
    run("R3", 4, 0, 0);

    // R4 N locked by first active word; later active word has data one at lowest
    dq[0] = 64'h0; gq[0] = 64'h80;
    dq[1] = '1;    gq[1] = 64'h1;
    run("R4", 2, 0, 0);

    // R5 hit only in middle word
    dq[0] = 64'h0; gq[0] = 64'hF0;
    dq[1] = 64'h100; gq[1] = 64'h100;
    dq[2] = 64'h0; gq[2] = 64'h1;
    run("R5", 3, 0, 0);

    // R6 active bits only in final word, top bit data one
    dq[0] = '1; gq[0] = '0;
    dq[1] = '1; gq[1] = '0;
    dq[2] = 64'h8000_0000_0000_0000; gq[2] = 64'h8000_0000_0000_0001;
    run("R6", 3, 0, 0);

    // R1 idle gap inside a stream
    dq[0] = 64'h2; gq[0] = 64'h2;
    dq[1] = 64'h0; gq[1] = 64'h4000_0000_0000_0000;
    run("R1", 2, 0, 1);

    // R10 start merged with first word, multi- and single-word
    dq[0] = 64'h0; gq[0] = 64'h10;
    dq[1] = 64'h0; gq[1] = 64'h1;
    run("R10", 2, 1, 0);
    dq[0] = 64'h5; gq[0] = 64'h5;
    run("R10", 1, 1, 0);

    // R8 random predicates of 1 to 4 words
    for (int t = 0; t < 400; t++) begin
      int nw = 1 + ($urandom % 4);
      for (int i = 0; i < 4; i++) begin
        dq[i] = {$urandom, $urandom};
        case ($urandom % 4)
          0: gq[i] = '0;
          1: gq[i] = 64'h1 << ($urandom % 64);
          2: gq[i] = {$urandom, $urandom} & {$urandom, $urandom};
          default: gq[i] = {$urandom, $urandom};
        endcase
      end
      run("R8", nw, bit'($urandom % 2), bit'($urandom % 4 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule